// File: doc/BRIEF.md
# Debug Halting Control and Status Register

This block is a 32-bit memory-mapped register that joins a debugger's access port, the processor core and a set of core status lines. A single register bus carries writes and reads. Each access carries a flag saying whether it came from the debugger or from the core. The register holds five control bits: debug enable, halt request, single step, interrupt mask and stall snap. These bits drive the halt, step, mask and snap strobes to the core, and those strobes are gated by debug enable. The register also reports core status. Some status bits are live views of core inputs. Two are sticky flags that clear when the register is read.

A write is protected by a key in its upper half. A write without the key changes nothing. The core pipeline, the register transfer engine and the bus fabric are outside the block. Each of them appears only as a level or strobe input, or as an output strobe.

Top module: `dbg_halt_csr`

## Requirements
- R1: After reset, every control bit (0, 1, 2, 3, 5) and both sticky bits (24, 25) read 0, and halt_req_o, step_o, mask_irq_o and snap_o are 0.
- R2: A write (reg_wr=1) changes no bit of the register unless reg_wdata[31:16] equals 16'hA05F.
- R3: Bit 0 (debug enable) takes reg_wdata[0] only on a keyed write with reg_from_dbg=1. A keyed write from the core leaves it unchanged.
- R4: halt_req_o, step_o, mask_irq_o and snap_o are each the stored bit 1, 2, 3 or 5 ANDed with bit 0. With bit 0 clear, all four are 0.
- R5: Bit 1 (halt) takes reg_wdata[1] on a keyed write. It is set by a core_halt_evt pulse, which wins over the write. It is cleared by core_rst, which wins over both.
- R6: Bits 2 (step) and 3 (interrupt mask) take reg_wdata[3:2] on a keyed write only while core_halted=1. Otherwise they hold their value.
- R7: A keyed write loads bit 5 (snap) with reg_wdata[5] AND the current bit 0 AND the current bit 1. Snap therefore cannot be set unless debug enable and halt are both already 1, and any keyed write with reg_wdata[5]=0 clears it.
- R8: Bit 25 is set on each clock with core_rst=1. It is cleared by the edge that ends a read cycle (reg_rd=1), except when core_rst is still 1. Two reads while core_rst is held both return 1.
- R9: Bit 24 is set on each clock with core_retired=1 and is cleared by the edge that ends a read. A set in the same cycle as a read wins. While snap_o is 1, bit 24 reads 0.
- R10: Bit 19 reads core_lockup AND NOT core_halted. Bits 18, 17 and 16 read core_sleeping, core_halted and core_xfer_done directly, with no register delay.
- R11: Bits 31:26, 23:20, 15:6 and 4 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_rd | input | 1 | Read strobe; sticky bits clear at the edge that ends this cycle |
| reg_from_dbg | input | 1 | Marks the access as coming from the debugger side |
| reg_wdata | input | 32 | Write data, with the key in bits 31:16 |
| reg_rdata | output | 32 | Current register view, combinational |
| core_rst | input | 1 | Core reset level |
| core_halt_evt | input | 1 | Core halted on its own event, such as a breakpoint |
| core_retired | input | 1 | Instruction-completed strobe |
| core_halted | input | 1 | Core is in debug (halted) state |
| core_sleeping | input | 1 | Core is sleeping |
| core_lockup | input | 1 | Core lockup condition |
| core_xfer_done | input | 1 | Core register transfer complete |
| halt_req_o | output | 1 | Halt request to the core |
| step_o | output | 1 | Single-step request to the core |
| mask_irq_o | output | 1 | Interrupt mask request to the core |
| snap_o | output | 1 | Force a stalled load/store to complete |

## Verification
Writes are tried in several forms:
- with and without the key, which separates key decoding from plain data capture;
- from both sides of the access flag, which shows whether debug enable is protected;
- while the core runs and while it is halted, which separates the step and mask gating from unconditional capture;
- with snap requested before and after halt is set, which checks that the snap condition uses the state before the write.

The sticky bits are driven with reads that come after a set, in the same cycle as a set, and while core reset is held. These cases tell clear-on-read apart from set-wins ordering. Live status inputs are swept over combinations of lockup, halted and sleeping to confirm the lockup qualification.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned KEY_W     = 16;
  localparam logic [KEY_W-1:0] WR_KEY = 16'hA05F;

  // Bit positions decoded by debugger software
  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_HALT    = 1;
  localparam int unsigned B_STEP    = 2;
  localparam int unsigned B_MASK    = 3;
  localparam int unsigned B_SNAP    = 5;
  localparam int unsigned B_XFER    = 16;
  localparam int unsigned B_HALTED  = 17;
  localparam int unsigned B_SLEEP   = 18;
  localparam int unsigned B_LOCK    = 19;
  localparam int unsigned B_RETIRE  = 24;
  localparam int unsigned B_CRST    = 25;

  // Sticky flag indices
  localparam int unsigned N_STICKY  = 2;
  localparam int unsigned S_RETIRE  = 0;
  localparam int unsigned S_CRST    = 1;

  typedef struct packed {
    logic snap;
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctl_t;
endpackage

// File: rtl/dhc_rst_sync.sv
module dhc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dhc_sticky.sv
module dhc_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q, d, ce;

    always_comb begin
      ce = set_i[i] | clr_i;
      d  = set_i[i];          // set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (ce) q <= d;
    end

    assign flag_o[i] = q;

    // R8 / R9: a set is never lost
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    // R8 / R9: read clears when no new set arrives
    p_clr_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/dhc_ctrl.sv
module dhc_ctrl
  import dhc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              from_dbg_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [5:0]        wbits_i,
  input  logic              core_rst_i,
  input  logic              halt_evt_i,
  input  logic              core_halted_i,
  output ctl_t              ctl_o
);
  ctl_t q, d;
  logic key_ok, ce;

  always_comb begin
    key_ok = wr_i && (key_i == WR_KEY);
    d = q;
    if (key_ok) begin
      if (from_dbg_i) d.en = wbits_i[B_EN];
      d.halt = wbits_i[B_HALT];
      if (core_halted_i) begin
        d.step = wbits_i[B_STEP];
        d.mask = wbits_i[B_MASK];
      end
      d.snap = wbits_i[B_SNAP] & q.en & q.halt;
    end
    if (halt_evt_i) d.halt = 1'b1;
    if (core_rst_i) d.halt = 1'b0;
    ce = key_ok | halt_evt_i | core_rst_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= d;
  end

  assign ctl_o = q;

  p_nokey_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_i && key_i == WR_KEY) && !halt_evt_i && !core_rst_i) |=> $stable(ctl_o));
  p_en_core_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!from_dbg_i) |=> $stable(ctl_o.en));
  p_halt_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_i |=> !ctl_o.halt);
  p_halt_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt_i && !core_rst_i) |=> ctl_o.halt);
  p_run_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halted_i) |=> ($stable(ctl_o.step) && $stable(ctl_o.mask)));
  p_snap_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_o.snap) |-> $past(ctl_o.en && ctl_o.halt));
endmodule

// File: rtl/dbg_halt_csr.sv
module dbg_halt_csr
  import dhc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_from_dbg,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              core_rst,
  input  logic              core_halt_evt,
  input  logic              core_retired,
  input  logic              core_halted,
  input  logic              core_sleeping,
  input  logic              core_lockup,
  input  logic              core_xfer_done,
  output logic              halt_req_o,
  output logic              step_o,
  output logic              mask_irq_o,
  output logic              snap_o
);
  logic                rst_q_n;
  ctl_t                ctl;
  logic [N_STICKY-1:0] stk_set, stk;
  logic                unused_wbits;

  assign unused_wbits = ^{reg_wdata[15:6], reg_wdata[4]};

  dhc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  dhc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .wr_i          (reg_wr),
    .from_dbg_i    (reg_from_dbg),
    .key_i         (reg_wdata[DATA_W-1:DATA_W-KEY_W]),
    .wbits_i       (reg_wdata[5:0]),
    .core_rst_i    (core_rst),
    .halt_evt_i    (core_halt_evt),
    .core_halted_i (core_halted),
    .ctl_o         (ctl)
  );

  always_comb begin
    stk_set           = '0;
    stk_set[S_RETIRE] = core_retired;
    stk_set[S_CRST]   = core_rst;
  end

  dhc_sticky #(.N(N_STICKY)) u_stk (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (stk_set),
    .clr_i  (reg_rd),
    .flag_o (stk)
  );

  always_comb begin
    halt_req_o = ctl.en & ctl.halt;
    step_o     = ctl.en & ctl.step;
    mask_irq_o = ctl.en & ctl.mask;
    snap_o     = ctl.en & ctl.snap;
  end

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[B_EN]     = ctl.en;
    reg_rdata[B_HALT]   = ctl.halt;
    reg_rdata[B_STEP]   = ctl.step;
    reg_rdata[B_MASK]   = ctl.mask;
    reg_rdata[B_SNAP]   = ctl.snap;
    reg_rdata[B_XFER]   = core_xfer_done;
    reg_rdata[B_HALTED] = core_halted;
    reg_rdata[B_SLEEP]  = core_sleeping;
    reg_rdata[B_LOCK]   = core_lockup & ~core_halted;
    reg_rdata[B_RETIRE] = stk[S_RETIRE] & ~snap_o;
    reg_rdata[B_CRST]   = stk[S_CRST];
  end

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!reg_rdata[B_EN]) |-> !(halt_req_o || step_o || mask_irq_o || snap_o));
  p_snap_retire_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    snap_o |-> !reg_rdata[B_RETIRE]);
  p_lock_halted_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    core_halted |-> !reg_rdata[B_LOCK]);
  p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (reg_rdata[31:26] == '0) && (reg_rdata[23:20] == '0) &&
    (reg_rdata[15:6] == '0) && !reg_rdata[4]);
endmodule

// File: tb/tb_dbg_halt_csr.sv
`timescale 1ns/1ps
module tb_dbg_halt_csr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, reg_from_dbg;
  logic [31:0] reg_wdata, reg_rdata;
  logic        core_rst, core_halt_evt, core_retired, core_halted;
  logic        core_sleeping, core_lockup, core_xfer_done;
  logic        halt_req_o, step_o, mask_irq_o, snap_o;

  always #2.5 clk = ~clk;   // 200 MHz

  dbg_halt_csr dut (.*);

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string phase  = "R1";

  // behavioural reference state
  bit m_en, m_halt, m_step, m_mask, m_snap, m_rt, m_rs;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata();
    logic [31:0] v = 32'h0;
    v[0]  = m_en;  v[1] = m_halt; v[2] = m_step; v[3] = m_mask; v[5] = m_snap;
    v[16] = core_xfer_done;
    v[17] = core_halted;
    v[18] = core_sleeping;
    v[19] = core_lockup && !core_halted;
    v[24] = m_rt && !(m_en && m_snap);
    v[25] = m_rs;
    return v;
  endfunction

  function automatic logic [3:0] m_outs();
    return {m_en & m_halt, m_en & m_step, m_en & m_mask, m_en & m_snap};
  endfunction

  task automatic model_edge();
    bit keyed = reg_wr && (reg_wdata[31:16] == 16'hA05F);
    bit n_en = m_en, n_halt = m_halt, n_step = m_step, n_mask = m_mask, n_snap = m_snap;
    if (keyed) begin
      if (reg_from_dbg) n_en = reg_wdata[0];
      n_halt = reg_wdata[1];
      if (core_halted) begin n_step = reg_wdata[2]; n_mask = reg_wdata[3]; end
      n_snap = reg_wdata[5] && m_en && m_halt;
    end
    if (core_halt_evt) n_halt = 1'b1;
    if (core_rst) n_halt = 1'b0;
    m_rt = core_retired ? 1'b1 : (reg_rd ? 1'b0 : m_rt);
    m_rs = core_rst     ? 1'b1 : (reg_rd ? 1'b0 : m_rs);
    m_en = n_en; m_halt = n_halt; m_step = n_step; m_mask = n_mask; m_snap = n_snap;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(reg_rdata === m_rdata(), phase, reg_rdata, m_rdata());
    check({halt_req_o, step_o, mask_irq_o, snap_o} === m_outs(), phase,
          {28'h0, halt_req_o, step_o, mask_irq_o, snap_o}, {28'h0, m_outs()});
  endtask

  task automatic wr(input logic [31:0] d, input bit dbg);
    reg_wr = 1'b1; reg_wdata = d; reg_from_dbg = dbg;
    cyc();
    reg_wr = 1'b0; reg_wdata = 32'h0; reg_from_dbg = 1'b0;
  endtask

  task automatic rd(output logic [31:0] v);
    reg_rd = 1'b1;
    v = reg_rdata;
    cyc();
    reg_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    rst_n = 1'b0;
    reg_wr = 0; reg_rd = 0; reg_from_dbg = 0; reg_wdata = 0;
    core_rst = 0; core_halt_evt = 0; core_retired = 0; core_halted = 0;
    core_sleeping = 0; core_lockup = 0; core_xfer_done = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(reg_rdata === 32'h0, "R1", reg_rdata, 32'h0);
    check({halt_req_o, step_o, mask_irq_o, snap_o} === 4'h0, "R1", {28'h0, halt_req_o, step_o, mask_irq_o, snap_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R3 and R4: core-side keyed write cannot enable; halt stored but gated
    phase = "R3";
    wr(32'hA05F_002F, 1'b0);
    check(reg_rdata[0] === 1'b0, "R3", reg_rdata, 32'h0);
    phase = "R4";
    check(halt_req_o === 1'b0, "R4", {31'h0, halt_req_o}, 32'h0);

    // R2: debugger write without key
    phase = "R2";
    wr(32'h0000_0001, 1'b1);
    wr(32'hA05E_0001, 1'b1);
    check(reg_rdata[0] === 1'b0, "R2", reg_rdata, 32'h0);

    // R3: keyed debugger write enables and halts
    phase = "R3";
    wr(32'hA05F_0003, 1'b1);
    check(halt_req_o === 1'b1, "R3", {31'h0, halt_req_o}, 32'h1);

    // R6: step/mask ignored while running, taken while halted
    phase = "R6";
    wr(32'hA05F_000F, 1'b1);
    check(step_o === 1'b0, "R6", {31'h0, step_o}, 32'h0);
    core_halted = 1'b1; cyc();
    wr(32'hA05F_000F, 1'b0);
    check({step_o, mask_irq_o} === 2'b11, "R6", {30'h0, step_o, mask_irq_o}, 32'h3);

    // R9 with R7: snap masks retire readout
    phase = "R7";
    wr(32'hA05F_002F, 1'b1);
    check(snap_o === 1'b1, "R7", {31'h0, snap_o}, 32'h1);
    phase = "R9";
    core_retired = 1'b1; cyc(); core_retired = 1'b0; cyc();
    check(reg_rdata[24] === 1'b0, "R9", reg_rdata, 32'h0);
    wr(32'hA05F_000F, 1'b1);
    check(reg_rdata[24] === 1'b1, "R9", reg_rdata, 32'h0100_0000);
    rd(v); rd(v);
    check(v[24] === 1'b0, "R9", v, 32'h0);
    // R9: set in the same cycle as a read wins
    core_retired = 1'b1; reg_rd = 1'b1; cyc(); core_retired = 1'b0; reg_rd = 1'b0;
    check(reg_rdata[24] === 1'b1, "R9", reg_rdata, 32'h0100_0000);

    // R5: halt event and core reset priority
    phase = "R5";
    core_halted = 1'b0;
    wr(32'hA05F_0001, 1'b1);
    core_halt_evt = 1'b1; reg_wr = 1'b1; reg_wdata = 32'hA05F_0001; reg_from_dbg = 1'b1;
    cyc();
    core_halt_evt = 1'b0; reg_wr = 1'b0; reg_from_dbg = 1'b0;
    check(reg_rdata[1] === 1'b1, "R5", reg_rdata, 32'h2);

    // R8: reset sticky held and cleared
    phase = "R8";
    core_rst = 1'b1; core_halt_evt = 1'b1; cyc(); core_halt_evt = 1'b0;
    check(reg_rdata[1] === 1'b0, "R5", reg_rdata, 32'h0);
    rd(v); check(v[25] === 1'b1, "R8", v, 32'h0200_0000);
    rd(v); check(v[25] === 1'b1, "R8", v, 32'h0200_0000);
    core_rst = 1'b0; cyc();
    rd(v); check(v[25] === 1'b1, "R8", v, 32'h0200_0000);
    rd(v); check(v[25] === 1'b0, "R8", v, 32'h0);

    // R7: snap refused while halt is 0
    phase = "R7";
    wr(32'hA05F_0021, 1'b1);
    check(snap_o === 1'b0, "R7", {31'h0, snap_o}, 32'h0);

    // R10: live status sweep
    phase = "R10";
    for (int i = 0; i < 16; i++) begin
      {core_lockup, core_halted, core_sleeping, core_xfer_done} = 4'(i);
      cyc();
    end
    core_lockup = 1'b1; core_halted = 1'b0; cyc();
    check(reg_rdata[19] === 1'b1, "R10", reg_rdata, 32'h0008_0000);
    core_lockup = 0; core_sleeping = 0; core_xfer_done = 0;

    // R11: reserved bits stay zero
    phase = "R11";
    core_halted = 1'b1;
    wr(32'hA05F_FFFF, 1'b1);
    check((reg_rdata & 32'hFCF0_FFD0) === 32'h0, "R11", reg_rdata & 32'hFCF0_FFD0, 32'h0);

    // R4: clearing enable gates every output, stored bits remain
    phase = "R4";
    wr(32'hA05F_002E, 1'b1);
    check({halt_req_o, step_o, mask_irq_o, snap_o} === 4'h0, "R4",
          {28'h0, halt_req_o, step_o, mask_irq_o, snap_o}, 32'h0);
    repeat (3) cyc();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule